// File: doc/BRIEF.md
# Variable-Length Serial Character Formatter

This block turns one byte, handed over with a load strobe, into a serial character of one to eight data bits, followed by an optional parity bit. A two-bit length code selects the character size. Three of the four codes give fixed lengths of 6, 7 or 8 bits. The remaining code selects a short-character mode, in which the length (1 to 5 bits) is carried inside the byte itself as a marker pattern above the data bits.

Data bits leave least significant first, one per clock, with `bit_vld` marking each valid serial bit. Parity is taken over the data bits actually sent and never over the marker. `done` marks the final bit of a character, and `busy` covers the whole character. The length code and the parity controls are captured with the byte, and a load that arrives while a character is in flight is dropped.

The controller has three states: `S_IDLE` (waiting), `S_DATA` (shifting data bits) and `S_PAR` (sending the parity bit). Its transitions are:
- `S_IDLE -> S_DATA` on an accepted load.
- `S_DATA -> S_DATA` while data bits remain.
- `S_DATA -> S_PAR` after the last data bit when parity is on.
- `S_DATA -> S_IDLE` after the last data bit when parity is off.
- `S_PAR -> S_IDLE` always.

Top module: `tx_char_fmt`

## Requirements
- R1: After reset, `busy`, `bit_vld` and `done` are 0 and `ser_out` is 1 (idle line level). The same values hold whenever no character is in flight.
- R2: Length code 2'b01 sends 6 data bits, 2'b10 sends 7 and 2'b11 sends 8. `bit_vld` is high for exactly that many data cycles, the first of them being the cycle after the load edge.
- R3: Data bits are sent least significant first: data cycle i carries `tx_byte[i]`.
- R4: With length code 2'b00, the byte's top bits select the length: 1111000D gives 1 bit, 111000DD gives 2, 11000DDD gives 3, 1000DDDD gives 4 and 000DDDDD gives 5. Only the D bits, which are the low bits, are sent.
- R5: With length code 2'b00, a byte that matches none of the R4 patterns is sent as a 5-bit character made of `tx_byte[4:0]`.
- R6: With `par_en`=1, one parity bit follows the last data bit. The total count of ones in the sent data bits and the parity bit is even when `par_odd`=0 and odd when `par_odd`=1. Marker bits do not count.
- R7: `done` is high in exactly one cycle per character: the cycle that carries the final bit (the parity bit if enabled, otherwise the last data bit).
- R8: A load while `busy`=1 is ignored, and the character in flight continues unchanged.
- R9: `busy` is high from the cycle after an accepted load through the final-bit cycle, and low in the cycle after. A load in that cycle is accepted.
- R10: Length code, `par_en` and `par_odd` are sampled only at an accepted load. Changing them mid-character has no effect on that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Load strobe for a new character |
| tx_byte | input | BYTE_W | Byte to send, right-justified |
| len_code | input | 2 | Length code (00 short mode, 01/10/11 = 6/7/8 bits) |
| par_en | input | 1 | Append parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| ser_out | output | 1 | Serial bit |
| bit_vld | output | 1 | Shift enable: `ser_out` carries a valid bit |
| done | output | 1 | Final bit of the character is on `ser_out` |
| busy | output | 1 | A character is in flight |

## Verification
A load sampled at clock edge k puts data bit 0 on `ser_out` after edge k, and each later bit follows one edge after the one before it. `done` coincides with the final bit, and `busy` falls one edge after that. The bench drives inputs on falling edges and samples every output on the falling edge between two rising edges. It compares each bit position against a model that is built from the length table and the parity rule, and then checks the idle cycle that follows. Loads and control changes injected in the middle of a character are checked by confirming that the remaining bits still follow the model of the originally loaded character.

// File: rtl/tx_fmt_pkg.sv
package tx_fmt_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_DATA = 2'd1,
        S_PAR  = 2'd2
    } fmt_state_e;

    typedef enum logic [1:0] {
        LEN_SHORT = 2'b00,
        LEN_M2    = 2'b01,
        LEN_M1    = 2'b10,
        LEN_FULL  = 2'b11
    } len_code_e;

endpackage

// File: rtl/tx_fmt_len_dec.sv
module tx_fmt_len_dec
    import tx_fmt_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic [1:0]        len_code,
    output logic [CNT_W-1:0]  char_len,
    output logic [BYTE_W-1:0] payload
);
    localparam int MARK_ZEROS = 3;
    localparam int SHORT_MAX  = BYTE_W - MARK_ZEROS;

    logic [CNT_W-1:0] short_len;
    logic             hit;

    // Short mode: k leading ones, then MARK_ZEROS zeros, give SHORT_MAX-k bits
    always_comb begin
        short_len = CNT_W'(SHORT_MAX);
        for (int k = 0; k < SHORT_MAX; k++) begin
            hit = 1'b1;
            for (int j = 0; j < k; j++) begin
                if (!tx_byte[BYTE_W-1-j]) hit = 1'b0;
            end
            for (int j = 0; j < MARK_ZEROS; j++) begin
                if (tx_byte[BYTE_W-1-k-j]) hit = 1'b0;
            end
            if (hit) short_len = CNT_W'(SHORT_MAX - k);
        end
    end

    always_comb begin
        unique case (len_code_e'(len_code))
            LEN_SHORT: char_len = short_len;
            LEN_M2:    char_len = CNT_W'(BYTE_W - 2);
            LEN_M1:    char_len = CNT_W'(BYTE_W - 1);
            LEN_FULL:  char_len = CNT_W'(BYTE_W);
            default:   char_len = CNT_W'(BYTE_W);
        endcase
    end

    // Keep only bits that are actually sent
    genvar g;
    generate
        for (g = 0; g < BYTE_W; g++) begin : g_mask
            assign payload[g] = tx_byte[g] & (CNT_W'(g) < char_len);
        end
    endgenerate

endmodule

// File: rtl/tx_fmt_parity.sv
module tx_fmt_parity #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] payload,
    input  logic              par_odd,
    output logic              par_bit
);
    // Parity bit brings the total count of ones to even (or odd when par_odd)
    assign par_bit = (^payload) ^ par_odd;
endmodule

// File: rtl/tx_char_fmt.sv
module tx_char_fmt
    import tx_fmt_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic [1:0]        len_code,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              ser_out,
    output logic              bit_vld,
    output logic              done,
    output logic              busy
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    fmt_state_e        state, state_nx;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bits_left;
    logic              par_q;
    logic              par_en_q;

    logic [CNT_W-1:0]  dec_len;
    logic [BYTE_W-1:0] dec_payload;
    logic              dec_par;
    logic              accept;
    logic              last_data;

    tx_fmt_len_dec #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_len_dec (
        .tx_byte  (tx_byte),
        .len_code (len_code),
        .char_len (dec_len),
        .payload  (dec_payload)
    );

    tx_fmt_parity #(.BYTE_W(BYTE_W)) u_parity (
        .payload (dec_payload),
        .par_odd (par_odd),
        .par_bit (dec_par)
    );

    assign accept    = (state == S_IDLE) && load;
    assign last_data = (bits_left == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (load) state_nx = S_DATA;
            S_DATA: if (last_data) state_nx = par_en_q ? S_PAR : S_IDLE;
            S_PAR:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // Datapath: captured character and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            bits_left <= '0;
            par_q     <= 1'b0;
            par_en_q  <= 1'b0;
        end else if (accept) begin
            shreg     <= dec_payload;
            bits_left <= dec_len - CNT_W'(1);
            par_q     <= dec_par;
            par_en_q  <= par_en;
        end else if (state == S_DATA) begin
            shreg     <= shreg >> 1;
            bits_left <= bits_left - CNT_W'(!last_data);
        end
    end

    // Outputs
    always_comb begin
        ser_out = 1'b1;
        bit_vld = 1'b0;
        done    = 1'b0;
        busy    = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_DATA: begin
                ser_out = shreg[0];
                bit_vld = 1'b1;
                busy    = 1'b1;
                done    = last_data && !par_en_q;
            end
            S_PAR: begin
                ser_out = par_q;
                bit_vld = 1'b1;
                busy    = 1'b1;
                done    = 1'b1;
            end
            default: ;
        endcase
    end

    // R1: idle means no bit on the line
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bit_vld && !done && ser_out));

    // R7: done marks a real bit and ends the character
    a_r7_done_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> bit_vld);

    // R9: busy drops right after the final bit
    a_r9_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R8: busy without done stays busy whatever load does
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R6: parity state lasts a single cycle
    a_r6_par_single: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PAR) |=> (state == S_IDLE));

    // R4: short mode length stays within 1..BYTE_W-3
    a_r4_short_range: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && len_code == 2'b00) |->
            (dec_len >= CNT_W'(1) && dec_len <= CNT_W'(BYTE_W - 3)));

    // R3: each data cycle shifts one position down
    a_r3_shift_order: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA && !last_data) |=> (ser_out == $past(shreg[1])));

endmodule

// File: tb/test_tx_char_fmt.sv
module test_tx_char_fmt;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic [1:0] len_code = 2'b00;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       ser_out, bit_vld, done, busy;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;  // 250 MHz

    tx_char_fmt #(.BYTE_W(8)) i_tx_char_fmt (
        .clk(clk), .rst_n(rst_n), .load(load), .tx_byte(tx_byte),
        .len_code(len_code), .par_en(par_en), .par_odd(par_odd),
        .ser_out(ser_out), .bit_vld(bit_vld), .done(done), .busy(busy)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_len(input logic [1:0] code, input logic [7:0] b);
        if (code == 2'b01) return 6;
        if (code == 2'b10) return 7;
        if (code == 2'b11) return 8;
        casez (b)
            8'b1111000?: return 1;
            8'b111000??: return 2;
            8'b11000???: return 3;
            8'b1000????: return 4;
            default:     return 5;  // 000DDDDD and all non-matching bytes
        endcase
    endfunction

    function automatic logic exp_par(input logic [7:0] b, input int n, input logic odd);
        logic p = odd;
        for (int i = 0; i < n; i++) p ^= b[i];
        return p;
    endfunction

    // Send one character and check every bit; disturb=1 injects a load and control flips
    task automatic send(input logic [7:0] b, input logic [1:0] code,
                        input logic pe, input logic po, input bit disturb, input string req);
        int n = exp_len(code, b);
        int total = n + (pe ? 1 : 0);
        logic eb;
        tx_byte = b; len_code = code; par_en = pe; par_odd = po; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        for (int i = 0; i < total; i++) begin
            eb = (i < n) ? b[i] : exp_par(b, n, po);
            chk({req, " R3 bit"}, {7'd0, ser_out}, {7'd0, eb});
            chk({req, " R2 vld"}, {7'd0, bit_vld}, 8'd1);
            chk({req, " R7 done"}, {7'd0, done}, {7'd0, (i == total - 1)});
            chk({req, " R9 busy"}, {7'd0, busy}, 8'd1);
            if (disturb && i == 0) begin
                // R8 / R10: these must not affect the character in flight
                load = 1'b1; tx_byte = ~b; len_code = ~code;
                par_en = ~pe; par_odd = ~po;
            end
            @(negedge clk);
            if (disturb) load = 1'b0;
        end
        load = 1'b0;
        chk({req, " R9 idle-after"}, {6'd0, busy, bit_vld}, 8'd0);
        chk({req, " R1 line idle"}, {6'd0, done, ser_out}, 8'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed = 32'h5eed;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        chk("R1 reset busy", {7'd0, busy}, 8'd0);
        chk("R1 reset vld", {7'd0, bit_vld}, 8'd0);
        chk("R1 reset done", {7'd0, done}, 8'd0);
        chk("R1 reset line", {7'd0, ser_out}, 8'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: fixed lengths
        send(8'hA5, 2'b01, 0, 0, 0, "R2 len6");
        send(8'h5A, 2'b10, 0, 0, 0, "R2 len7");
        send(8'hC3, 2'b11, 0, 0, 0, "R2 len8");
        // Directed: short-mode markers
        send(8'hF1, 2'b00, 0, 0, 0, "R4 len1");
        send(8'hE2, 2'b00, 0, 0, 0, "R4 len2");
        send(8'hC5, 2'b00, 0, 0, 0, "R4 len3");
        send(8'h8B, 2'b00, 0, 0, 0, "R4 len4");
        send(8'h15, 2'b00, 0, 0, 0, "R4 len5");
        // Non-matching short bytes
        send(8'hFF, 2'b00, 0, 0, 0, "R5 allones");
        send(8'h6D, 2'b00, 1, 0, 0, "R5 nomatch par");
        send(8'hF8, 2'b00, 0, 0, 0, "R5 f8");
        // Parity excludes marker bits
        send(8'hF1, 2'b00, 1, 0, 0, "R6 even len1");
        send(8'hF0, 2'b00, 1, 1, 0, "R6 odd len1");
        send(8'hFF, 2'b11, 1, 1, 0, "R6 odd len8");
        // Ignored load and mid-character control changes
        send(8'h3C, 2'b11, 1, 0, 1, "R8 R10 disturb");
        send(8'hE1, 2'b00, 0, 1, 1, "R8 R10 short disturb");

        // Random mix
        for (int t = 0; t < 300; t++) begin
            send(8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                 ($urandom % 4) == 0, "rand");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule